// File: doc/BRIEF.md
# Zero-Cross Synchronized Setting Commit Controller

This block sits between the serial control receiver of an audio volume/tone processor and the registers that drive its analog switches. Each received 44-bit control word carries input select, input gain, main volume, bass, treble, fader level, fader front/rear choice and loudness. The word also carries a commit mode and a detector tap choice. The block decides when those settings reach the active per-channel output registers, so that switch changes can land on a signal zero crossing and produce no audible click.

The mode and tap fields take effect at the end of the frame that carries them. This lets one transfer move the detector to the block being changed, arm zero-cross mode and deliver the new data. In zero-cross mode the remaining settings are held pending until the synchronized zero-cross pulse arrives from the chosen tap. If the signal is too small or too slow to cross, a programmable cycle count forces the commit. In immediate mode the settings commit at the frame end. A two-bit channel field chooses which channel's registers are written, and one value of that field is the power-on initial-setting transfer, which also raises a precharge flag.

Top module: `zc_commit_ctrl`

## Requirements
- R1: After reset both channel configuration outputs are zero and `cfg_applied`, `pending`, `commit_strobe`, `precharge` and `zc_tap` are 0. `cfg_applied` becomes 1 with the first commit and stays 1.
- R2: A committed word W maps to a channel configuration as follows: bits [2:0]=W[2:0] input select, [6:3]=W[7:4] gain, [14:7]=W[15:8] volume, [19:15]={W[40],W[19:16]} bass, [24:20]={W[42],W[27:24]} treble, [28:25]=W[31:28] fader level, [29]=W[34] fader front, [30]=W[35] loudness.
- R3: A frame with W[37:36]=00 is zero-cross mode and goes pending. Any other value commits at the clock edge that samples `frame_end`, so `commit_strobe` and the new configuration appear together in the following cycle.
- R4: At every frame end, `zc_tap` takes {W[39],W[38]} (0 selector, 1 volume, 2 tone, 3 fader) and `zc_armed` takes (W[37:36]==00) at once, in both modes.
- R5: A pending word commits at the edge where `zc_pulse` is sampled high, with `commit_by_timeout`=0. A pulse in the capture cycle, or a pulse while nothing is pending, has no effect.
- R6: If no pulse arrives, a pending word commits at the T-th edge after capture, T=`timeout_cycles`, with `commit_by_timeout`=1. A T of 0 acts as 1. A pulse at the timeout edge gives `commit_by_timeout`=0.
- R7: The channel field {W[33],W[32]} writes: 01 right only, 10 left only, 11 both, and 00 both.
- R8: `precharge` is set by a commit whose channel field is 00 and cleared by any other commit.
- R9: A frame arriving while a word is pending replaces it. A zero-cross frame restarts the timeout from its own capture. An immediate frame commits itself and drops the pending word, so the dropped word is never applied.
- R10: Bits W[3], W[23:20], W[41] and W[43] have no effect on any output.
- R11: `commit_strobe` is high for exactly one cycle per commit, and the configuration outputs change only in a cycle where it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end | input | 1 | One-cycle pulse: a complete control word is present |
| frame_word | input | 44 | Received control word, valid with frame_end |
| zc_pulse | input | 1 | Synchronized zero-crossing pulse from the selected tap |
| timeout_cycles | input | TMR_W | No-signal timeout in clock cycles |
| zc_tap | output | 2 | Detector tap select for the zero-cross comparator |
| zc_armed | output | 1 | Last frame selected zero-cross mode |
| pending | output | 1 | A word is waiting for a crossing or timeout |
| commit_strobe | output | 1 | One-cycle pulse when settings were committed |
| commit_by_timeout | output | 1 | Last commit was forced by the timeout |
| cfg_applied | output | 1 | At least one commit since reset (outputs unmuted) |
| precharge | output | 1 | Last commit was an initial-setting transfer |
| left_cfg | output | 31 | Active left channel configuration |
| right_cfg | output | 31 | Active right channel configuration |

## Verification
The hardest situations to reach are the edges where two events coincide: a zero-cross pulse in the very cycle a word is captured, a pulse on the exact timeout edge, and a second frame landing while the first is still pending. The bench steps through these by counting clock edges from the capture edge. It places the pulse at every offset from one up to one short of the timeout for each tap, sweeps the timeout itself from zero to eight, and sends a replacing frame partway through a wait. It then checks that the first word never reaches the outputs and that the timeout is counted from the second capture.

// File: rtl/zc_commit_ctrl.sv
module zc_commit_ctrl #(
  parameter int TMR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [43:0]      frame_word,
  input  logic             zc_pulse,
  input  logic [TMR_W-1:0] timeout_cycles,
  output logic [1:0]       zc_tap,
  output logic             zc_armed,
  output logic             pending,
  output logic             commit_strobe,
  output logic             commit_by_timeout,
  output logic             cfg_applied,
  output logic             precharge,
  output logic [30:0]      left_cfg,
  output logic [30:0]      right_cfg
);

  localparam int CFG_W = 31;

  function automatic logic [CFG_W-1:0] unpack_cfg(input logic [43:0] w);
    return {w[35], w[34], w[31:28], w[42], w[27:24], w[40], w[19:16],
            w[15:8], w[7:4], w[2:0]};
  endfunction

  logic [43:0]      held;
  logic [TMR_W-1:0] timer;
  logic             imm_go, zc_hit, tmo_hit, go;
  logic [43:0]      src;
  logic [1:0]       chan;
  logic             tmo_reached;

  assign tmo_reached = ({1'b0, timer} + 1'b1) >= {1'b0, timeout_cycles};
  assign imm_go  = frame_end && (frame_word[37:36] != 2'b00);
  assign zc_hit  = pending && !frame_end && zc_pulse;
  assign tmo_hit = pending && !frame_end && !zc_pulse && tmo_reached;
  assign go      = imm_go || zc_hit || tmo_hit;
  assign src     = imm_go ? frame_word : held;
  assign chan    = {src[33], src[32]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held              <= '0;
      timer             <= '0;
      pending           <= 1'b0;
      zc_tap            <= 2'd0;
      zc_armed          <= 1'b0;
      commit_strobe     <= 1'b0;
      commit_by_timeout <= 1'b0;
      cfg_applied       <= 1'b0;
      precharge         <= 1'b0;
      left_cfg          <= '0;
      right_cfg         <= '0;
    end else begin
      commit_strobe <= go;
      if (go) begin
        commit_by_timeout <= tmo_hit;
        cfg_applied       <= 1'b1;
        precharge         <= (chan == 2'b00);
        if (chan != 2'b01) left_cfg  <= unpack_cfg(src);
        if (chan != 2'b10) right_cfg <= unpack_cfg(src);
      end
      if (frame_end) begin
        zc_tap   <= {frame_word[39], frame_word[38]};
        zc_armed <= (frame_word[37:36] == 2'b00);
        pending  <= (frame_word[37:36] == 2'b00);
        held     <= frame_word;
        timer    <= '0;
      end else if (go) begin
        pending <= 1'b0;
      end else if (pending) begin
        timer <= timer + 1'b1;
      end
    end
  end

endmodule

module zc_commit_chk #(
  parameter int TMR_W = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_end,
  input logic        zc_pulse,
  input logic [1:0]  zc_tap,
  input logic        pending,
  input logic        commit_strobe,
  input logic        commit_by_timeout,
  input logic        cfg_applied,
  input logic [30:0] left_cfg,
  input logic [30:0] right_cfg
);

  assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_strobe |-> ($past(pending) || $past(frame_end)));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_strobe |-> ($stable(left_cfg) && $stable(right_cfg)));

  assert_pending_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> commit_strobe);

  assert_timeout_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_strobe && commit_by_timeout) |-> !$past(zc_pulse));

  assert_muted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_applied |-> (left_cfg == '0 && right_cfg == '0));

  assert_tap_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zc_tap) |-> $past(frame_end));

  assert_applied_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_applied) |-> cfg_applied);

endmodule

bind zc_commit_ctrl zc_commit_chk #(.TMR_W(TMR_W)) u_zc_commit_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .zc_pulse(zc_pulse),
  .zc_tap(zc_tap), .pending(pending), .commit_strobe(commit_strobe),
  .commit_by_timeout(commit_by_timeout), .cfg_applied(cfg_applied),
  .left_cfg(left_cfg), .right_cfg(right_cfg)
);

// File: tb/test_zc_commit_ctrl.sv
module test_zc_commit_ctrl;
  localparam int TMR_W = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frame_end;
  logic [43:0]      frame_word;
  logic             zc_pulse;
  logic [TMR_W-1:0] timeout_cycles;
  logic [1:0]       zc_tap;
  logic             zc_armed, pending, commit_strobe, commit_by_timeout;
  logic             cfg_applied, precharge;
  logic [30:0]      left_cfg, right_cfg;

  always #5 clk = ~clk;

  zc_commit_ctrl #(.TMR_W(TMR_W)) i_zc_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_word(frame_word),
    .zc_pulse(zc_pulse), .timeout_cycles(timeout_cycles), .zc_tap(zc_tap),
    .zc_armed(zc_armed), .pending(pending), .commit_strobe(commit_strobe),
    .commit_by_timeout(commit_by_timeout), .cfg_applied(cfg_applied),
    .precharge(precharge), .left_cfg(left_cfg), .right_cfg(right_cfg)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [30:0] m_l = '0, m_r = '0;
  logic        m_pre = 1'b0, m_app = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] exp_cfg(input logic [43:0] w);
    logic [30:0] c;
    c[2:0]   = w[2:0];
    c[6:3]   = w[7:4];
    c[14:7]  = w[15:8];
    c[18:15] = w[19:16];
    c[19]    = w[40];
    c[23:20] = w[27:24];
    c[24]    = w[42];
    c[28:25] = w[31:28];
    c[29]    = w[34];
    c[30]    = w[35];
    return c;
  endfunction

  function automatic logic [43:0] mkw(input logic [1:0] chan, input logic [1:0] mode,
                                      input logic [1:0] tap, input int seed);
    logic [31:0] s;
    logic [43:0] w;
    s = 32'h9E3779B9 * (seed + 1);
    w = {s[11:0], s ^ 32'h5A5AC3C3};
    w[33] = chan[1]; w[32] = chan[0];
    w[37:36] = mode;
    w[39] = tap[1]; w[38] = tap[0];
    w[3] = 1'b0; w[43] = 1'b0; w[41] = 1'b0; w[23:20] = 4'h0;
    return w;
  endfunction

  task automatic model(input logic [43:0] w);
    logic [1:0] ch;
    ch = {w[33], w[32]};
    if (ch == 2'b00 || ch[1]) m_l = exp_cfg(w);
    if (ch == 2'b00 || ch[0]) m_r = exp_cfg(w);
    m_pre = (ch == 2'b00);
    m_app = 1'b1;
  endtask

  task automatic chk_outs(input string req);
    chk(left_cfg == m_l, req, left_cfg, m_l);
    chk(right_cfg == m_r, req, right_cfg, m_r);
    chk(precharge == m_pre, {req, " precharge R8"}, precharge, m_pre);
    chk(cfg_applied == m_app, {req, " applied R1"}, cfg_applied, m_app);
  endtask

  task automatic send(input logic [43:0] w, input logic with_pulse);
    @(negedge clk);
    frame_end = 1'b1; frame_word = w; zc_pulse = with_pulse;
    @(negedge clk);
    frame_end = 1'b0; zc_pulse = 1'b0;
  endtask

  task automatic pulse_now();
    zc_pulse = 1'b1;
    @(negedge clk);
    zc_pulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [43:0] w, w2;
    int teff;
    rst_n = 1'b0; frame_end = 1'b0; frame_word = '0; zc_pulse = 1'b0;
    timeout_cycles = 6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(left_cfg == 0 && right_cfg == 0, "R1 reset cfg", {left_cfg, right_cfg}, 0);
    chk({cfg_applied, pending, commit_strobe, precharge} == 0, "R1 reset flags",
        {cfg_applied, pending, commit_strobe, precharge}, 0);
    chk(zc_tap == 0, "R1 reset tap", zc_tap, 0);

    // R5 pulse with nothing pending
    pulse_now();
    chk(!commit_strobe && !cfg_applied, "R5 idle pulse ignored", {commit_strobe, cfg_applied}, 0);

    // R7 R8 initial-setting transfer, immediate
    w = mkw(2'b00, 2'b11, 2'b00, 100);
    send(w, 1'b0);
    model(w);
    chk(commit_strobe, "R3 immediate strobe", commit_strobe, 1);
    chk_outs("R7 init both R2");
    @(negedge clk);
    chk(!commit_strobe, "R11 strobe one cycle", commit_strobe, 0);

    // R3 R4 R7 immediate sweep
    for (int tap = 0; tap < 4; tap++)
      for (int ch = 0; ch < 4; ch++)
        for (int md = 1; md < 4; md++) begin
          w = mkw(ch[1:0], md[1:0], tap[1:0], tap * 16 + ch * 4 + md);
          send(w, 1'b0);
          model(w);
          chk(commit_strobe, "R3 immediate commit", commit_strobe, 1);
          chk(zc_tap == tap[1:0], "R4 tap immediate", zc_tap, tap);
          chk(!zc_armed && !pending, "R4 armed clear", {zc_armed, pending}, 0);
          chk_outs("R7 channel write R2");
        end

    // R5 zero-cross sweep over tap and pulse offset
    timeout_cycles = 6;
    for (int tap = 0; tap < 4; tap++)
      for (int p = 1; p < 6; p++) begin
        w = mkw(p[1:0], 2'b00, tap[1:0], 200 + tap * 8 + p);
        send(w, 1'b0);
        chk(zc_tap == tap[1:0] && zc_armed, "R4 tap zc", {zc_armed, zc_tap}, {1'b1, tap[1:0]});
        chk(pending && !commit_strobe, "R3 zc waits", {pending, commit_strobe}, 2'b10);
        repeat (p - 1) @(negedge clk);
        chk(!commit_strobe, "R5 no early commit", commit_strobe, 0);
        chk_outs("R5 held before crossing");
        pulse_now();
        model(w);
        chk(commit_strobe && !commit_by_timeout, "R5 zc commit",
            {commit_strobe, commit_by_timeout}, 2'b10);
        chk_outs("R5 zc cfg");
        @(negedge clk);
        chk(!commit_strobe && !pending, "R11 single strobe", {commit_strobe, pending}, 0);
      end

    // R6 timeout sweep
    for (int t = 0; t < 9; t++) begin
      timeout_cycles = t;
      teff = (t == 0) ? 1 : t;
      w = mkw(2'b11, 2'b00, 2'b10, 300 + t);
      send(w, 1'b0);
      repeat (teff - 1) @(negedge clk);
      chk(pending && !commit_strobe, "R6 before timeout", {pending, commit_strobe}, 2'b10);
      @(negedge clk);
      model(w);
      chk(commit_strobe && commit_by_timeout, "R6 timeout commit",
          {commit_strobe, commit_by_timeout}, 2'b11);
      chk_outs("R6 timeout cfg");
    end

    // R5 pulse in capture cycle ignored
    timeout_cycles = 4;
    w = mkw(2'b10, 2'b00, 2'b01, 400);
    send(w, 1'b1);
    repeat (3) @(negedge clk);
    chk(pending && !commit_strobe, "R5 capture pulse ignored", {pending, commit_strobe}, 2'b10);
    @(negedge clk);
    model(w);
    chk(commit_strobe && commit_by_timeout, "R5 capture pulse then timeout",
        {commit_strobe, commit_by_timeout}, 2'b11);

    // R6 pulse on timeout edge
    timeout_cycles = 3;
    w = mkw(2'b01, 2'b00, 2'b11, 410);
    send(w, 1'b0);
    repeat (2) @(negedge clk);
    pulse_now();
    model(w);
    chk(commit_strobe && !commit_by_timeout, "R6 pulse wins at timeout edge",
        {commit_strobe, commit_by_timeout}, 2'b10);
    chk_outs("R6 tie cfg");

    // R9 zc replacement restarts wait
    timeout_cycles = 5;
    w = mkw(2'b11, 2'b00, 2'b01, 500);
    send(w, 1'b0);
    repeat (2) @(negedge clk);
    w2 = mkw(2'b11, 2'b00, 2'b10, 501);
    send(w2, 1'b0);
    chk(zc_tap == 2'd2 && pending && !commit_strobe, "R9 replace tap",
        {zc_tap, pending, commit_strobe}, {2'd2, 2'b10});
    repeat (4) @(negedge clk);
    chk(!commit_strobe, "R9 timer restarted", commit_strobe, 0);
    chk_outs("R9 nothing applied yet");
    @(negedge clk);
    model(w2);
    chk(commit_strobe && commit_by_timeout, "R9 replaced commit",
        {commit_strobe, commit_by_timeout}, 2'b11);
    chk_outs("R9 second word applied");

    // R9 immediate frame pre-empts pending
    timeout_cycles = 20;
    w = mkw(2'b11, 2'b00, 2'b00, 600);
    send(w, 1'b0);
    repeat (2) @(negedge clk);
    w2 = mkw(2'b11, 2'b11, 2'b01, 601);
    send(w2, 1'b0);
    model(w2);
    chk(commit_strobe && !pending, "R9 immediate pre-empts", {commit_strobe, pending}, 2'b10);
    chk_outs("R9 immediate cfg");
    @(negedge clk);
    pulse_now();
    chk(!commit_strobe, "R9 dropped word stays dropped", commit_strobe, 0);
    chk_outs("R9 outputs after dropped");

    // R10 ignored bits
    w = mkw(2'b00, 2'b11, 2'b00, 700);
    w2 = w | 44'hA00_00F0_0008;
    send(w2, 1'b0);
    model(w);
    chk_outs("R10 ignored bits");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule